// File: doc/BRIEF.md
# Dual-Clock Watermark Data Buffer

This block holds data words moving between a host register port and a card-side data engine. The two sides run on unrelated clocks. Two independent first-in first-out stores are used. The receive store takes words from the card side and hands them to the host one at a time through a single read port. The transmit store takes host writes one word at a time and feeds them to the card side.

On the host side, two ready flags report when enough data (receive) or enough free room (transmit) has built up for the host to move a whole block of words. The block size is the programmed watermark. Once a flag has fired, it cannot fire again until the host has moved exactly one watermark's worth of words, and the host clears each flag by writing a one to it.

On the card side, words move in bursts of programmable length. A burst only starts when the whole burst is sure to fit, and a one-cycle done pulse closes it.

Top module: `wm_data_buffer`

## Requirements
- R1: While the resets are held, both ready flags, both error bits, both card-side burst-active outputs and both done pulses are 0, and the host read data is 0.
- R2: Words leave each store in the same order they entered it. The receive store runs from the card push side to the host read port, and the transmit store from host writes to the card pop side.
- R3: The host read-ready flag sets when the receive store holds at least the effective read watermark. A programmed watermark of 0 counts as 1, and any value above 128 counts as 128.
- R4: The host write-ready flag sets when the transmit store has at least the effective write watermark of free words. The same 0-to-1 and 128 limits apply.
- R5: Writing 1 to a flag's clear input drops the flag. After a flag has set, it is not set again until exactly one watermark's worth of host words has been moved in that direction. After that, the level is compared again.
- R6: A host read while the receive store is empty returns 0 and sets the sticky underrun bit, which stays set until reset.
- R7: A host write while the transmit store is full is discarded and never reaches the card side. It sets the sticky overrun bit.
- R8: A card-side burst starts only while its request is high and the store holds at least one burst length of data (transmit) or free room (receive). A programmed burst length of 0 counts as 1.
- R9: A burst accepts exactly burst-length words. Burst-active then drops, and the done output is high for one card clock cycle.
- R10: Reset empties both stores. Words held before the reset never appear afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host peripheral clock |
| hrst | input | 1 | Synchronous active-high reset, host domain |
| h_rd_en | input | 1 | Host pops one word from the receive store |
| h_rd_data | output | DW | Head word of the receive store, 0 when empty |
| h_wr_en | input | 1 | Host pushes one word into the transmit store |
| h_wr_data | input | DW | Word pushed by the host |
| h_rd_wm | input | AW+1 | Read watermark setting |
| h_wr_wm | input | AW+1 | Write watermark setting |
| h_rd_rdy | output | 1 | Read block ready flag |
| h_wr_rdy | output | 1 | Write block ready flag |
| h_rd_rdy_clr | input | 1 | Write-1 clear of the read ready flag |
| h_wr_rdy_clr | input | 1 | Write-1 clear of the write ready flag |
| h_underrun | output | 1 | Sticky: read from empty store |
| h_overrun | output | 1 | Sticky: write to full store |
| cclk | input | 1 | Card master clock |
| crst | input | 1 | Synchronous active-high reset, card domain |
| c_rx_blen | input | BW | Receive burst length setting |
| c_rx_req | input | 1 | Card has words to push |
| c_rx_active | output | 1 | Receive burst in progress |
| c_rx_push | input | 1 | Card offers a word this cycle |
| c_rx_data | input | DW | Word offered by the card |
| c_rx_done | output | 1 | One-cycle pulse after the last receive word |
| c_tx_blen | input | BW | Transmit burst length setting |
| c_tx_req | input | 1 | Card wants words to send |
| c_tx_active | output | 1 | Transmit burst in progress |
| c_tx_pop | input | 1 | Card takes the head word this cycle |
| c_tx_data | output | DW | Head word of the transmit store |
| c_tx_done | output | 1 | One-cycle pulse after the last transmit word |

## Verification
The hardest situation to reach is the held-off flag. The flag has been cleared, but a block is still in progress, so the store level stays above the watermark and the flag must still stay low. The stimulus loads six words against a watermark of two and clears the flag before any read. It then reads one word at a time, sampling the flag after each read to see that it comes back only after the second read. The second hard case is a full transmit store. The test sets the write watermark above the depth so the flag's block spans all 128 words, fills the store with host writes, pushes one extra word, and then drains everything through the card side to show that the extra word never arrives.

// File: rtl/wmb_pkg.sv
package wmb_pkg;

    parameter int unsigned FN_W = 16;

    typedef enum logic {
        BURST_IDLE,
        BURST_RUN
    } burst_st_e;

    typedef struct packed {
        logic flag;
        logic pend;
    } rdy_st_t;

    function automatic logic [FN_W-1:0] bin_to_gray(input logic [FN_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [FN_W-1:0] gray_to_bin(input logic [FN_W-1:0] g);
        logic [FN_W-1:0] b;
        b[FN_W-1] = g[FN_W-1];
        for (int i = FN_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // zero maps to one, anything above hi maps to hi
    function automatic logic [FN_W-1:0] fn_limit(input logic [FN_W-1:0] v,
                                                 input logic [FN_W-1:0] hi);
        if (v == '0) return FN_W'(1);
        if (v > hi)  return hi;
        return v;
    endfunction

endpackage

// File: rtl/wmb_afifo.sv
module wmb_afifo
    import wmb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 7
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [AW:0]   wfill,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    output logic [DW-1:0] rdata,
    output logic [AW:0]   rfill
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
    logic [PW-1:0] rbin_w, wbin_r;
    logic          full, empty;

    always_comb begin
        rbin_w = PW'(gray_to_bin(FN_W'(rg_s2)));
        wbin_r = PW'(gray_to_bin(FN_W'(wg_s2)));
        wfill  = wbin - rbin_w;
        rfill  = wbin_r - rbin;
        full   = (wfill == PW'(DEPTH));
        empty  = (rfill == '0);
    end

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
            rg_s1 <= '0;
            rg_s2 <= '0;
        end else begin
            rg_s1 <= rgray;
            rg_s2 <= rg_s1;
            if (we && !full) begin
                wbin  <= wbin + 1'b1;
                wgray <= PW'(bin_to_gray(FN_W'(wbin + 1'b1)));
            end
        end
    end

    always_ff @(posedge wclk) begin
        if (we && !full) mem[wbin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
            wg_s1 <= '0;
            wg_s2 <= '0;
        end else begin
            wg_s1 <= wgray;
            wg_s2 <= wg_s1;
            if (re && !empty) begin
                rbin  <= rbin + 1'b1;
                rgray <= PW'(bin_to_gray(FN_W'(rbin + 1'b1)));
            end
        end
    end

    assign rdata = empty ? '0 : mem[rbin[AW-1:0]];

endmodule

// File: rtl/wmb_ready.sv
module wmb_ready
    import wmb_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] wm,
    input  logic          clr,
    input  logic          beat,
    output logic          flag
);
    rdy_st_t       st;
    logic [LW-1:0] cnt, blk;

    assign flag = st.flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            cnt <= '0;
            blk <= '0;
        end else begin
            if (clr) st.flag <= 1'b0;
            if (st.pend) begin
                if (beat) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == blk - 1'b1) st.pend <= 1'b0;
                end
            end else if (!st.flag && level >= wm) begin
                st.flag <= 1'b1;
                st.pend <= 1'b1;
                cnt     <= '0;
                blk     <= wm;
            end
        end
    end

endmodule

// File: rtl/wmb_burst.sv
module wmb_burst
    import wmb_pkg::*;
#(
    parameter int LW = 8,
    parameter int BW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [BW-1:0] len,
    input  logic [LW-1:0] avail,
    input  logic          xfer,
    output logic          active,
    output logic          beat,
    output logic          done
);
    burst_st_e     st;
    logic [BW-1:0] cnt;

    assign active = (st == BURST_RUN);
    assign beat   = active && xfer;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= BURST_IDLE;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == BURST_IDLE) begin
                if (req && avail >= LW'(len)) begin
                    st  <= BURST_RUN;
                    cnt <= '0;
                end
            end else if (xfer) begin
                if (cnt == len - 1'b1) begin
                    st   <= BURST_IDLE;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wm_data_buffer.sv
module wm_data_buffer
    import wmb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 7,
    parameter int BW = 5
) (
    input  logic          hclk,
    input  logic          hrst,
    input  logic          h_rd_en,
    output logic [DW-1:0] h_rd_data,
    input  logic          h_wr_en,
    input  logic [DW-1:0] h_wr_data,
    input  logic [AW:0]   h_rd_wm,
    input  logic [AW:0]   h_wr_wm,
    output logic          h_rd_rdy,
    output logic          h_wr_rdy,
    input  logic          h_rd_rdy_clr,
    input  logic          h_wr_rdy_clr,
    output logic          h_underrun,
    output logic          h_overrun,
    input  logic          cclk,
    input  logic          crst,
    input  logic [BW-1:0] c_rx_blen,
    input  logic          c_rx_req,
    output logic          c_rx_active,
    input  logic          c_rx_push,
    input  logic [DW-1:0] c_rx_data,
    output logic          c_rx_done,
    input  logic [BW-1:0] c_tx_blen,
    input  logic          c_tx_req,
    output logic          c_tx_active,
    input  logic          c_tx_pop,
    output logic [DW-1:0] c_tx_data,
    output logic          c_tx_done
);
    localparam int DEPTH  = 1 << AW;
    localparam int LW     = AW + 1;
    localparam int BL_MAX = (1 << BW) - 1;

    logic [LW-1:0] rd_wm_eff, wr_wm_eff;
    logic [BW-1:0] rx_len, tx_len;
    logic [LW-1:0] rx_hfill, rx_cfill, tx_hfill, tx_cfill;
    logic          rx_hempty, tx_hfull;
    logic          rx_beat, tx_beat;

    always_comb begin
        rd_wm_eff = LW'(fn_limit(FN_W'(h_rd_wm), FN_W'(DEPTH)));
        wr_wm_eff = LW'(fn_limit(FN_W'(h_wr_wm), FN_W'(DEPTH)));
        rx_len    = BW'(fn_limit(FN_W'(c_rx_blen), FN_W'(BL_MAX)));
        tx_len    = BW'(fn_limit(FN_W'(c_tx_blen), FN_W'(BL_MAX)));
        rx_hempty = (rx_hfill == '0);
        tx_hfull  = (tx_hfill == LW'(DEPTH));
    end

    wmb_afifo #(.DW(DW), .AW(AW)) u_rx_fifo (
        .wclk (cclk),    .wrst (crst),  .we    (rx_beat),
        .wdata(c_rx_data), .wfill(rx_cfill),
        .rclk (hclk),    .rrst (hrst),  .re    (h_rd_en),
        .rdata(h_rd_data), .rfill(rx_hfill)
    );

    wmb_afifo #(.DW(DW), .AW(AW)) u_tx_fifo (
        .wclk (hclk),    .wrst (hrst),  .we    (h_wr_en),
        .wdata(h_wr_data), .wfill(tx_hfill),
        .rclk (cclk),    .rrst (crst),  .re    (tx_beat),
        .rdata(c_tx_data), .rfill(tx_cfill)
    );

    wmb_ready #(.LW(LW)) u_rd_rdy (
        .clk  (hclk), .rst(hrst), .level(rx_hfill), .wm(rd_wm_eff),
        .clr  (h_rd_rdy_clr), .beat(h_rd_en && !rx_hempty), .flag(h_rd_rdy)
    );

    wmb_ready #(.LW(LW)) u_wr_rdy (
        .clk  (hclk), .rst(hrst), .level(LW'(DEPTH) - tx_hfill), .wm(wr_wm_eff),
        .clr  (h_wr_rdy_clr), .beat(h_wr_en && !tx_hfull), .flag(h_wr_rdy)
    );

    wmb_burst #(.LW(LW), .BW(BW)) u_rx_burst (
        .clk   (cclk), .rst(crst), .req(c_rx_req), .len(rx_len),
        .avail (LW'(DEPTH) - rx_cfill), .xfer(c_rx_push),
        .active(c_rx_active), .beat(rx_beat), .done(c_rx_done)
    );

    wmb_burst #(.LW(LW), .BW(BW)) u_tx_burst (
        .clk   (cclk), .rst(crst), .req(c_tx_req), .len(tx_len),
        .avail (tx_cfill), .xfer(c_tx_pop),
        .active(c_tx_active), .beat(tx_beat), .done(c_tx_done)
    );

    always_ff @(posedge hclk) begin
        if (hrst) begin
            h_underrun <= 1'b0;
            h_overrun  <= 1'b0;
        end else begin
            if (h_rd_en && rx_hempty) h_underrun <= 1'b1;
            if (h_wr_en && tx_hfull)  h_overrun  <= 1'b1;
        end
    end

endmodule

// File: rtl/wmb_checker.sv
module wmb_checker #(
    parameter int LW    = 8,
    parameter int BW    = 5,
    parameter int DEPTH = 128
) (
    input logic          hclk,
    input logic          hrst,
    input logic          cclk,
    input logic          crst,
    input logic          h_rd_rdy,
    input logic          h_wr_rdy,
    input logic [LW-1:0] rx_hfill,
    input logic [LW-1:0] tx_hfill,
    input logic [LW-1:0] rd_wm_eff,
    input logic [LW-1:0] wr_wm_eff,
    input logic          h_underrun,
    input logic          h_overrun,
    input logic          c_tx_active,
    input logic [LW-1:0] tx_cfill,
    input logic [BW-1:0] tx_len,
    input logic          c_rx_active,
    input logic          c_rx_done,
    input logic [LW-1:0] rx_cfill
);

    assert_rdrdy_level_R3: assert property (@(posedge hclk) disable iff (hrst)
        $rose(h_rd_rdy) |-> $past(rx_hfill >= rd_wm_eff));

    assert_wrrdy_space_R4: assert property (@(posedge hclk) disable iff (hrst)
        $rose(h_wr_rdy) |-> $past((LW'(DEPTH) - tx_hfill) >= wr_wm_eff));

    assert_underrun_sticky_R6: assert property (@(posedge hclk) disable iff (hrst)
        h_underrun |=> h_underrun);

    assert_overrun_sticky_R7: assert property (@(posedge hclk) disable iff (hrst)
        h_overrun |=> h_overrun);

    assert_tx_start_R8: assert property (@(posedge cclk) disable iff (crst)
        $rose(c_tx_active) |-> $past(tx_cfill >= LW'(tx_len)));

    assert_rx_done_R9: assert property (@(posedge cclk) disable iff (crst)
        c_rx_done |-> ($past(c_rx_active) && !c_rx_active));

    always @(posedge cclk) begin
        if (!crst) begin
            assert_no_overflow_R2: assert (rx_cfill <= LW'(DEPTH));
        end
    end

endmodule

bind wm_data_buffer wmb_checker u_chk (
    .hclk       (hclk),
    .hrst       (hrst),
    .cclk       (cclk),
    .crst       (crst),
    .h_rd_rdy   (h_rd_rdy),
    .h_wr_rdy   (h_wr_rdy),
    .rx_hfill   (rx_hfill),
    .tx_hfill   (tx_hfill),
    .rd_wm_eff  (rd_wm_eff),
    .wr_wm_eff  (wr_wm_eff),
    .h_underrun (h_underrun),
    .h_overrun  (h_overrun),
    .c_tx_active(c_tx_active),
    .tx_cfill   (tx_cfill),
    .tx_len     (tx_len),
    .c_rx_active(c_rx_active),
    .c_rx_done  (c_rx_done),
    .rx_cfill   (rx_cfill)
);

// File: tb/sim_wm_data_buffer.sv
module sim_wm_data_buffer;
    localparam int HCLK_PERIOD = 10;
    localparam int CCLK_PERIOD = 14;
    localparam int DW = 32;
    localparam int AW = 7;
    localparam int BW = 5;

    logic          hclk = 0, cclk = 0;
    logic          hrst = 1, crst = 1;
    logic          h_rd_en = 0, h_wr_en = 0;
    logic [DW-1:0] h_rd_data, h_wr_data = '0;
    logic [AW:0]   h_rd_wm = 4, h_wr_wm = 4;
    logic          h_rd_rdy, h_wr_rdy;
    logic          h_rd_rdy_clr = 0, h_wr_rdy_clr = 0;
    logic          h_underrun, h_overrun;
    logic [BW-1:0] c_rx_blen = 1, c_tx_blen = 1;
    logic          c_rx_req = 0, c_rx_push = 0, c_tx_req = 0, c_tx_pop = 0;
    logic [DW-1:0] c_rx_data = '0, c_tx_data;
    logic          c_rx_active, c_rx_done, c_tx_active, c_tx_done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit ended  = 0;

    always #(HCLK_PERIOD/2) hclk = ~hclk;
    always #(CCLK_PERIOD/2) cclk = ~cclk;

    wm_data_buffer #(.DW(DW), .AW(AW), .BW(BW)) u0 (
        .hclk(hclk), .hrst(hrst), .h_rd_en(h_rd_en), .h_rd_data(h_rd_data),
        .h_wr_en(h_wr_en), .h_wr_data(h_wr_data), .h_rd_wm(h_rd_wm), .h_wr_wm(h_wr_wm),
        .h_rd_rdy(h_rd_rdy), .h_wr_rdy(h_wr_rdy), .h_rd_rdy_clr(h_rd_rdy_clr),
        .h_wr_rdy_clr(h_wr_rdy_clr), .h_underrun(h_underrun), .h_overrun(h_overrun),
        .cclk(cclk), .crst(crst), .c_rx_blen(c_rx_blen), .c_rx_req(c_rx_req),
        .c_rx_active(c_rx_active), .c_rx_push(c_rx_push), .c_rx_data(c_rx_data),
        .c_rx_done(c_rx_done), .c_tx_blen(c_tx_blen), .c_tx_req(c_tx_req),
        .c_tx_active(c_tx_active), .c_tx_pop(c_tx_pop), .c_tx_data(c_tx_data),
        .c_tx_done(c_tx_done)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic settle();
        repeat (16) @(negedge cclk);
        @(negedge hclk);
    endtask

    task automatic do_reset(input bit check_r1);
        hrst = 1; crst = 1;
        repeat (3) @(negedge cclk);
        @(negedge hclk);
        if (check_r1) begin
            chk(h_rd_rdy == 0,    "R1 rd_rdy", h_rd_rdy, 0);
            chk(h_wr_rdy == 0,    "R1 wr_rdy", h_wr_rdy, 0);
            chk(h_underrun == 0 && h_overrun == 0, "R1 errors", {h_underrun, h_overrun}, 0);
            chk(c_rx_active == 0 && c_tx_active == 0, "R1 active", {c_rx_active, c_tx_active}, 0);
            chk(c_rx_done == 0 && c_tx_done == 0, "R1 done", {c_rx_done, c_tx_done}, 0);
            chk(h_rd_data == 0,   "R1 rd_data", h_rd_data, 0);
        end
        hrst = 0;
        @(negedge cclk);
        crst = 0;
    endtask

    task automatic card_push(input int n, input int blen, input int len, input logic [DW-1:0] base);
        int sent;
        int beats;
        sent = 0; beats = 0;
        c_rx_blen = BW'(blen);
        c_rx_req  = 1;
        while (sent < n) begin
            @(negedge cclk);
            c_rx_push = 0;
            if (c_rx_done) begin
                chk(beats == len, "R9 rx burst size", beats, len);
                beats = 0;
            end
            if (c_rx_active) begin
                c_rx_push = 1;
                c_rx_data = base + DW'(sent);
                sent++;
                beats++;
            end
        end
        @(negedge cclk);
        c_rx_push = 0;
        c_rx_req  = 0;
        chk(c_rx_done == 1, "R9 rx done", c_rx_done, 1);
        chk(beats == len,   "R9 rx last burst", beats, len);
        @(negedge cclk);
        chk(c_rx_done == 0, "R9 rx done width", c_rx_done, 0);
    endtask

    task automatic card_pop(input int n, input int blen, input logic [DW-1:0] base);
        int got;
        int beats;
        got = 0; beats = 0;
        c_tx_blen = BW'(blen);
        c_tx_req  = 1;
        while (got < n) begin
            @(negedge cclk);
            c_tx_pop = 0;
            if (c_tx_done) begin
                chk(beats == blen, "R9 tx burst size", beats, blen);
                beats = 0;
            end
            if (c_tx_active) begin
                chk(c_tx_data == base + DW'(got), "R2 tx order", c_tx_data, base + DW'(got));
                c_tx_pop = 1;
                got++;
                beats++;
            end
        end
        @(negedge cclk);
        c_tx_pop = 0;
        c_tx_req = 0;
        chk(c_tx_done == 1, "R9 tx done", c_tx_done, 1);
        chk(beats == blen,  "R9 tx last burst", beats, blen);
    endtask

    task automatic host_read(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge hclk);
            chk(h_rd_data == base + DW'(i), "R2 rx order", h_rd_data, base + DW'(i));
            h_rd_en = 1;
            @(negedge hclk);
            h_rd_en = 0;
        end
    endtask

    task automatic host_write(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge hclk);
            h_wr_data = base + DW'(i);
            h_wr_en   = 1;
            @(negedge hclk);
            h_wr_en   = 0;
        end
    endtask

    task automatic clr_rd();
        @(negedge hclk); h_rd_rdy_clr = 1;
        @(negedge hclk); h_rd_rdy_clr = 0;
        repeat (2) @(negedge hclk);
    endtask

    task automatic clr_wr();
        @(negedge hclk); h_wr_rdy_clr = 1;
        @(negedge hclk); h_wr_rdy_clr = 0;
        repeat (2) @(negedge hclk);
    endtask

    task automatic test_reset();
        do_reset(1);
    endtask

    task automatic test_read_wm();
        h_rd_wm = 4;
        do_reset(0);
        card_push(3, 1, 1, 32'hA000_0000);
        settle();
        chk(h_rd_rdy == 0, "R3 below watermark", h_rd_rdy, 0);
        card_push(1, 1, 1, 32'hA000_0003);
        settle();
        chk(h_rd_rdy == 1, "R3 at watermark", h_rd_rdy, 1);
        host_read(4, 32'hA000_0000);
        clr_rd();
        chk(h_rd_rdy == 0, "R3 drained", h_rd_rdy, 0);
    endtask

    task automatic test_block_hold();
        h_rd_wm = 2;
        do_reset(0);
        card_push(6, 3, 3, 32'hB000_0000);
        settle();
        chk(h_rd_rdy == 1, "R5 first event", h_rd_rdy, 1);
        clr_rd();
        chk(h_rd_rdy == 0, "R5 cleared, block pending", h_rd_rdy, 0);
        host_read(1, 32'hB000_0000);
        repeat (3) @(negedge hclk);
        chk(h_rd_rdy == 0, "R5 held mid block", h_rd_rdy, 0);
        host_read(1, 32'hB000_0001);
        repeat (3) @(negedge hclk);
        chk(h_rd_rdy == 1, "R5 re-armed after block", h_rd_rdy, 1);
        clr_rd();
        host_read(2, 32'hB000_0002);
        repeat (3) @(negedge hclk);
        chk(h_rd_rdy == 1, "R5 third event", h_rd_rdy, 1);
        clr_rd();
        host_read(2, 32'hB000_0004);
        repeat (3) @(negedge hclk);
        chk(h_rd_rdy == 0, "R5 empty after blocks", h_rd_rdy, 0);
    endtask

    task automatic test_underrun();
        h_rd_wm = 0;
        do_reset(0);
        @(negedge hclk);
        chk(h_rd_data == 0,  "R6 empty read data", h_rd_data, 0);
        chk(h_underrun == 0, "R6 before", h_underrun, 0);
        h_rd_en = 1;
        @(negedge hclk);
        h_rd_en = 0;
        chk(h_underrun == 1, "R6 set", h_underrun, 1);
        card_push(1, 0, 1, 32'hC000_0000);
        settle();
        chk(h_rd_rdy == 1,   "R3 watermark zero as one", h_rd_rdy, 1);
        chk(h_underrun == 1, "R6 sticky", h_underrun, 1);
        host_read(1, 32'hC000_0000);
    endtask

    task automatic test_write_path();
        h_wr_wm = 100;
        do_reset(0);
        settle();
        chk(h_wr_rdy == 1, "R4 empty store has room", h_wr_rdy, 1);
        clr_wr();
        host_write(100, 32'hD000_0000);
        settle();
        chk(h_wr_rdy == 0, "R4 room below watermark", h_wr_rdy, 0);
        card_pop(80, 20, 32'hD000_0000);
        settle();
        chk(h_wr_rdy == 1, "R4 room restored", h_wr_rdy, 1);
        c_tx_blen = 31;
        c_tx_req  = 1;
        repeat (10) @(negedge cclk);
        chk(c_tx_active == 0, "R8 burst waits for data", c_tx_active, 0);
        c_tx_req = 0;
        card_pop(20, 20, 32'hD000_0050);
    endtask

    task automatic test_overrun();
        h_wr_wm = 200;
        do_reset(0);
        settle();
        chk(h_wr_rdy == 1, "R4 watermark clamp 128", h_wr_rdy, 1);
        clr_wr();
        host_write(128, 32'hE000_0000);
        chk(h_overrun == 0, "R7 not yet", h_overrun, 0);
        host_write(1, 32'hEEEE_EEEE);
        chk(h_overrun == 1, "R7 set", h_overrun, 1);
        settle();
        chk(h_wr_rdy == 0, "R4 full store", h_wr_rdy, 0);
        card_pop(128, 16, 32'hE000_0000);
        c_tx_blen = 1;
        c_tx_req  = 1;
        repeat (12) @(negedge cclk);
        chk(c_tx_active == 0, "R7 dropped word absent", c_tx_active, 0);
        c_tx_req = 0;
        settle();
        chk(h_overrun == 1, "R7 sticky", h_overrun, 1);
    endtask

    task automatic test_flush();
        h_rd_wm = 4;
        do_reset(0);
        card_push(4, 2, 2, 32'hF000_0000);
        settle();
        chk(h_rd_rdy == 1, "R10 before reset", h_rd_rdy, 1);
        do_reset(0);
        settle();
        chk(h_rd_rdy == 0,  "R10 flag after reset", h_rd_rdy, 0);
        chk(h_rd_data == 0, "R10 store emptied", h_rd_data, 0);
        card_push(4, 4, 4, 32'hF100_0000);
        settle();
        chk(h_rd_rdy == 1, "R10 watermark kept", h_rd_rdy, 1);
        host_read(4, 32'hF100_0000);
    endtask

    always @(posedge hclk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_read_wm();
        test_block_hold();
        test_underrun();
        test_write_path();
        test_overrun();
        test_flush();
        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule